// File: doc/BRIEF.md
# Buffered Down-Counting Timer Bank

The block holds five down-counting channels, each with a count buffer and a compare buffer, plus one control word. Software reaches all of it over a word-addressed register bus. The bus has a single-cycle write strobe and combinational read data. Each channel decrements its counter by one on every clock cycle in which its own tick-enable input is high.

A channel is driven by edges of its control bits, not by their levels:

- A rising edge on the manual-update bit copies the count buffer into the counter.
- A rising edge on the start bit begins counting.
- A falling edge on the start bit freezes the counter.

When a tick arrives while the counter is already at zero, the channel expires and issues a one-cycle pulse. It then either reloads from the count buffer and keeps running, or it halts. If it halts, the hardware also clears its start bit, so software sees the channel as stopped.

Top module: `pulse_timer_bank`

## Requirements
- R1: After reset, every count buffer, compare buffer, counter and the control word read zero, all channels are halted and `expire` is low.
- R2: Count buffers sit at byte offset 0x0C+12n for channels 0 to 4. Compare buffers sit at 0x10+12n for channels 0 to 3. Each reads back the value last written to it.
- R3: A control write that takes a channel's manual-update bit from 0 to 1 copies that channel's count buffer into its counter. Writing the bit again while it is already 1 loads nothing.
- R4: A control write that takes a start bit from 0 to 1 makes the channel decrement once per cycle with its `tick_en` bit high. Ticks to a halted channel change nothing.
- R5: A control write that takes a start bit from 1 to 0 halts the channel and holds its count. A later 0-to-1 edge resumes counting from the held value without reloading.
- R6: A tick to a running channel whose counter is zero is an expiry. The channel's `expire` bit is high for exactly the one cycle after that clock edge.
- R7: On expiry with the channel's auto-reload bit set, the counter takes the count-buffer value and the channel keeps running.
- R8: On expiry with auto-reload clear, the channel halts, its counter stays at zero, and its start bit in the control word (offset 0x08) reads back as 0.
- R9: The control word puts channel 0's start, manual-update, output-invert and auto-reload bits at 0, 1, 2 and 3. Channels 1 to 3 use the same order from bit 4n+4. Channel 4 has start at bit 20, manual-update at 21 and auto-reload at 22.
- R10: When a single control write raises both the manual-update and the start bit of a channel, the load takes effect first and counting starts from the loaded value.
- R11: Offsets 0x00, 0x04 and 0x44 to 0x4C, and any offset not a multiple of four, read zero. Writes to them change no register.
- R12: The observation offsets 0x14+12n (channels 0 to 3) and 0x40 (channel 4) return the live counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_en | input | 5 | Per-channel count enable |
| expire | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
The bench goes after these corner cases:

- **Manual-update bit rewritten while already high.** A level-sensitive design would reload on every rewrite and throw away the running count.
- **Stop, then restart.** A design that reloaded on restart would lose the held value.
- **Manual-update and start raised in one write.** A wrong ordering would count from the stale counter instead of the freshly loaded value.
- **Expiry without auto-reload.** A design that skipped the hardware clear of the start bit would show a running channel in the control word while the channel sits halted.
- **Irregular control layout.** This covers the displaced auto-reload bit of the last channel and the gap between channel 0's bits and the rest. A misplaced bit would leave the wrong channel halted or reloading.
- **Unmapped offsets.** These include the misaligned ones and 0x44, which channel 4's observation register would otherwise collide with. Each must read zero and leave every register unchanged.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

   localparam int NUM_CH   = 5;
   localparam int OFS_CTRL = 'h08;
   localparam int CH_STEP  = 12;

   // control word layout: irregular, last channel has no invert bit
   function automatic int start_pos(input int ch);
      return (ch == 0) ? 0 : 4 * ch + 4;
   endfunction

   function automatic int manual_pos(input int ch);
      return start_pos(ch) + 1;
   endfunction

   function automatic int reload_pos(input int ch);
      return (ch == NUM_CH - 1) ? start_pos(ch) + 2 : start_pos(ch) + 3;
   endfunction

   function automatic int cbuf_ofs(input int ch);
      return 'h0C + CH_STEP * ch;
   endfunction

   function automatic int cmp_ofs(input int ch);
      return 'h10 + CH_STEP * ch;
   endfunction

   function automatic int obs_ofs(input int ch);
      return (ch == NUM_CH - 1) ? 'h40 : 'h14 + CH_STEP * ch;
   endfunction

   function automatic bit has_cmp(input int ch);
      return ch != NUM_CH - 1;
   endfunction

endpackage

// File: rtl/ptb_channel.sv
module ptb_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             start_rise,
   input  logic             start_fall,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             stop_req,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             exp_q;
   logic             wrap;

   // a load in the same cycle takes priority over the tick
   assign wrap     = run_q && tick && (cnt_q == '0) && !load;
   assign stop_req = wrap && !reload_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= wrap;
         if (load) begin
            cnt_q <= load_val;
         end else if (wrap) begin
            if (reload_en) cnt_q <= load_val;
         end else if (run_q && tick) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (start_rise)                  run_q <= 1'b1;
         else if (start_fall || stop_req) run_q <= 1'b0;
      end
   end

   assign cnt     = cnt_q;
   assign running = run_q;
   assign expire  = exp_q;

endmodule

// File: rtl/ptb_regs.sv
module ptb_regs
   import ptb_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [DATA_W-1:0]              rdata,
   input  logic [NUM_CH-1:0]              stop_req,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_obs,
   output logic [NUM_CH-1:0]              load,
   output logic [NUM_CH-1:0]              start_rise,
   output logic [NUM_CH-1:0]              start_fall,
   output logic [NUM_CH-1:0]              reload_en,
   output logic [NUM_CH-1:0][CNT_W-1:0]   cbuf,
   output logic [DATA_W-1:0]              ctrl
);

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] ctrl_d;
   logic              ctrl_wr;
   logic              ctrl_hit;
   logic [DATA_W-1:0] rd_part [NUM_CH];

   assign ctrl_hit = (addr == ADDR_W'(OFS_CTRL));
   assign ctrl_wr  = wr && ctrl_hit;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int SP = start_pos(ch);
      localparam int MP = manual_pos(ch);
      localparam int RP = reload_pos(ch);
      logic [CNT_W-1:0] cbuf_q;
      logic             cb_hit;
      logic             ob_hit;

      assign cb_hit = (addr == ADDR_W'(cbuf_ofs(ch)));
      assign ob_hit = (addr == ADDR_W'(obs_ofs(ch)));

      assign load[ch]       = ctrl_wr &&  wdata[MP] && !ctrl_q[MP];
      assign start_rise[ch] = ctrl_wr &&  wdata[SP] && !ctrl_q[SP];
      assign start_fall[ch] = ctrl_wr && !wdata[SP] &&  ctrl_q[SP];
      assign reload_en[ch]  = ctrl_q[RP];

      always_ff @(posedge clk) begin
         if (!rst_n)            cbuf_q <= '0;
         else if (wr && cb_hit) cbuf_q <= wdata[CNT_W-1:0];
      end
      assign cbuf[ch] = cbuf_q;

      if (has_cmp(ch)) begin : g_cmp
         logic [CNT_W-1:0] cmp_q;
         logic             cm_hit;
         assign cm_hit = (addr == ADDR_W'(cmp_ofs(ch)));
         always_ff @(posedge clk) begin
            if (!rst_n)            cmp_q <= '0;
            else if (wr && cm_hit) cmp_q <= wdata[CNT_W-1:0];
         end
         assign rd_part[ch] = cb_hit ? DATA_W'(cbuf_q)
                            : cm_hit ? DATA_W'(cmp_q)
                            : ob_hit ? DATA_W'(cnt_obs[ch])
                            : '0;
      end else begin : g_nocmp
         assign rd_part[ch] = cb_hit ? DATA_W'(cbuf_q)
                            : ob_hit ? DATA_W'(cnt_obs[ch])
                            : '0;
      end
   end

   // hardware clear of a start bit wins over the written value
   always_comb begin
      ctrl_d = ctrl_wr ? wdata : ctrl_q;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (stop_req[ch]) ctrl_d[start_pos(ch)] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   always_comb begin
      rdata = ctrl_hit ? ctrl_q : '0;
      for (int ch = 0; ch < NUM_CH; ch++) rdata = rdata | rd_part[ch];
   end

   assign ctrl = ctrl_q;

endmodule

// File: rtl/pulse_timer_bank.sv
module pulse_timer_bank
   import ptb_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [4:0]        tick_en,
   output logic [4:0]        expire
);

   localparam int TOP_BIT = reload_pos(NUM_CH - 1);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0x4C");
   end
   if (DATA_W <= TOP_BIT) begin : g_bad_data
      $error("DATA_W too narrow for the control word");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (NUM_CH != 5) begin : g_bad_ch
      $error("control layout is fixed to five channels");
   end

   logic [NUM_CH-1:0]            load_v, srise_v, sfall_v, rel_v, stop_v, run_vec;
   logic [NUM_CH-1:0][CNT_W-1:0] cbuf_v, cnt_vec;
   logic [DATA_W-1:0]            ctrl_word;

   ptb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .stop_req   (stop_v),
      .cnt_obs    (cnt_vec),
      .load       (load_v),
      .start_rise (srise_v),
      .start_fall (sfall_v),
      .reload_en  (rel_v),
      .cbuf       (cbuf_v),
      .ctrl       (ctrl_word)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      ptb_channel #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick_en[ch]),
         .load       (load_v[ch]),
         .start_rise (srise_v[ch]),
         .start_fall (sfall_v[ch]),
         .reload_en  (rel_v[ch]),
         .load_val   (cbuf_v[ch]),
         .cnt        (cnt_vec[ch]),
         .running    (run_vec[ch]),
         .stop_req   (stop_v[ch]),
         .expire     (expire[ch])
      );
   end

endmodule

// File: rtl/ptb_chk.sv
module ptb_chk
   import ptb_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_wr,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic [DATA_W-1:0]            bus_rdata,
   input logic [4:0]                   tick_en,
   input logic [4:0]                   expire,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec,
   input logic [NUM_CH-1:0]            run_vec,
   input logic [DATA_W-1:0]            ctrl_word
);

   logic ctrl_wr;
   logic addr_ok;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

   always_comb begin
      addr_ok = (bus_addr == ADDR_W'(OFS_CTRL));
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(cbuf_ofs(c)) || bus_addr == ADDR_W'(obs_ofs(c)))
            addr_ok = 1'b1;
         if (has_cmp(c) && bus_addr == ADDR_W'(cmp_ofs(c)))
            addr_ok = 1'b1;
      end
   end

   // R11
   unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ok |-> bus_rdata == '0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int SP = start_pos(c);
      localparam int RP = reload_pos(c);

      // R6
      expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[c] |-> $past(tick_en[c]) && $past(run_vec[c]) && ($past(cnt_vec[c]) == '0));

      // R4
      run_tracks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         run_vec[c] == ctrl_word[SP]);

      // R8
      halt_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[c] && !$past(ctrl_word[RP]) |-> !run_vec[c] && !ctrl_word[SP] && cnt_vec[c] == '0);

      // R7
      keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[c] && $past(ctrl_word[RP]) && !$past(ctrl_wr) |-> run_vec[c]);

      // R5
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(run_vec[c]) && !$past(ctrl_wr) |-> cnt_vec[c] == $past(cnt_vec[c]));
   end

endmodule

bind pulse_timer_bank ptb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .tick_en   (tick_en),
   .expire    (expire),
   .cnt_vec   (cnt_vec),
   .run_vec   (run_vec),
   .ctrl_word (ctrl_word)
);

// File: tb/tb_pulse_timer_bank.sv
module tb_pulse_timer_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  tick_en = '0;
   logic [4:0]  expire;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   pulse_timer_bank dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_en   (tick_en),
      .expire    (expire)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic tick_for(input logic [4:0] m, input int n);
      @(negedge clk);
      tick_en = m;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_en = '0;
   endtask

   task automatic t_reset();
      for (int a = 'h0C; a <= 'h40; a += 4) rd_chk("R1 reset reg", 7'(a), 32'h0);
      rd_chk("R1 reset ctrl", 7'h08, 32'h0);
      chk("R1 reset expire", 32'(expire), 32'h0);
   endtask

   task automatic t_buffers();
      for (int n = 0; n < 5; n++) wr(7'('h0C + 12 * n), 32'h100 + n);
      for (int n = 0; n < 4; n++) wr(7'('h10 + 12 * n), 32'h200 + n);
      for (int n = 0; n < 5; n++) rd_chk("R2 count buffer", 7'('h0C + 12 * n), 32'h100 + n);
      for (int n = 0; n < 4; n++) rd_chk("R2 compare buffer", 7'('h10 + 12 * n), 32'h200 + n);
      rd_chk("R12 obs untouched by buffer write", 7'h14, 32'h0);
   endtask

   task automatic t_load_start_stop();
      wr(7'h0C, 32'd10);
      wr(7'h08, 32'h3);                          // R10 load and start together
      rd_chk("R10 loaded on joint write", 7'h14, 32'd10);
      tick_for(5'b00001, 4);
      rd_chk("R4 decrement per tick", 7'h14, 32'd6);
      wr(7'h08, 32'h3);                          // R3 manual bit held high
      rd_chk("R3 no reload without edge", 7'h14, 32'd6);
      wr(7'h08, 32'h2);                          // R5 stop
      tick_for(5'b00001, 3);
      rd_chk("R5 count held while stopped", 7'h14, 32'd6);
      wr(7'h08, 32'h3);                          // R5 restart
      tick_for(5'b00001, 2);
      rd_chk("R5 resumes from held value", 7'h14, 32'd4);
      wr(7'h08, 32'h1);
      wr(7'h08, 32'h3);                          // R3 manual rising edge
      rd_chk("R3 reload on manual edge", 7'h14, 32'd10);
      wr(7'h08, 32'h0);
      tick_for(5'b00001, 2);
      rd_chk("R4 halted ignores tick", 7'h14, 32'd10);
   endtask

   task automatic t_expire_halt();
      wr(7'h18, 32'd2);
      wr(7'h08, 32'h300);                        // ch1 start bit 8, manual bit 9
      @(negedge clk);
      tick_en = 5'b00010;
      for (int k = 1; k <= 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R6 expiry pulse timing", 32'(expire), (k == 3) ? 32'h2 : 32'h0);
      end
      tick_en = '0;
      @(posedge clk);
      @(negedge clk);
      chk("R6 pulse lasts one cycle", 32'(expire), 32'h0);
      rd_chk("R8 start bit cleared by hardware", 7'h08, 32'h200);
      rd_chk("R8 count stays zero", 7'h20, 32'h0);
      @(negedge clk);
      tick_en = 5'b00010;
      @(posedge clk);
      @(negedge clk);
      tick_en = '0;
      chk("R8 halted channel no further expiry", 32'(expire), 32'h0);
   endtask

   task automatic t_reload();
      wr(7'h3C, 32'd1);
      wr(7'h08, 32'h700000);                     // ch4 bits 20, 21, 22
      @(negedge clk);
      tick_en = 5'b10000;
      for (int k = 1; k <= 4; k++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R7 periodic expiry", 32'(expire), (k % 2 == 0) ? 32'h10 : 32'h0);
      end
      tick_en = '0;
      rd_chk("R7 start bit kept", 7'h08, 32'h700000);
      rd_chk("R7 reloaded count", 7'h40, 32'd1);
   endtask

   task automatic t_layout();
      wr(7'h24, 32'd0);
      wr(7'h30, 32'd0);
      wr(7'h08, 32'h000B3000);                   // R9 ch2 bits 12,13; ch3 bits 16,17,19
      @(negedge clk);
      tick_en = 5'b01100;
      @(posedge clk);
      @(negedge clk);
      tick_en = '0;
      chk("R9 ch2 and ch3 expire", 32'(expire), 32'h0C);
      rd_chk("R9 only ch2 start cleared", 7'h08, 32'h000B2000);
      rd_chk("R12 ch4 obs after stop", 7'h40, 32'd1);
   endtask

   task automatic t_unmapped();
      logic [6:0] holes [6] = '{7'h00, 7'h04, 7'h44, 7'h48, 7'h4C, 7'h0D};
      for (int i = 0; i < 6; i++) wr(holes[i], 32'hFFFF_FFFF);
      for (int i = 0; i < 6; i++) rd_chk("R11 unmapped reads zero", holes[i], 32'h0);
      rd_chk("R11 ctrl unchanged", 7'h08, 32'h000B2000);
      rd_chk("R11 buffer unchanged", 7'h0C, 32'd10);
      rd_chk("R11 compare unchanged", 7'h10, 32'h200);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_buffers();
      t_load_start_stop();
      t_expire_halt();
      t_reload();
      t_layout();
      t_unmapped();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule